// File: doc/BRIEF.md
# Buffer Invalidate and Debug Gate Control Register

This block is a 24-bit control register in a dual-core subsystem. Software writes it through a plain synchronous register port with one-cycle strobes and a single select. Four command bits each request invalidation of one buffer: the read buffer or the write buffer of core 0 or core 1. A command bit drives its request line as a level from the write until that buffer returns its acknowledge. The acknowledge clears the bit, so software can poll the register to see when the work is done.

Two enable bits in the top of the same word decide, one per direction, whether a debug request raised by one core reaches the other core. The gated outputs are combinational. Reserved bits have no storage behind them.

Top module: `buf_inval_ctl`

## Requirements
- R1: After synchronous reset, every stored bit is 0, all four invalidate requests are low and a read returns 0x000000.
- R2: Writing 1 to bit 0 (core 0 read buffer), bit 1 (core 0 write buffer), bit 2 (core 1 read buffer) or bit 3 (core 1 write buffer) raises `inv_req` at the same index on the next clock edge. The request stays high as a level until that buffer acknowledges.
- R3: An acknowledge on `inv_ack[n]` while bit n is pending clears bit n on that clock edge, and `inv_req[n]` drops.
- R4: Writing 0 to a pending invalidate bit does not cancel it.
- R5: When a write of 1 and the acknowledge for the same bit fall in the same cycle, the bit ends cleared.
- R6: An acknowledge that arrives while its bit is clear has no effect, and the bit can still be set later.
- R7: Bit 23 gates the debug request from core 1 to core 0: `dbg_to_c0` equals `dbg_from_c1` when the bit is 1 and is 0 when the bit is 0.
- R8: Bit 22 gates the debug request from core 0 to core 1: `dbg_to_c1` equals `dbg_from_c0` when the bit is 1 and is 0 when the bit is 0.
- R9: Bits 21 to 4 are not stored and always read as 0, whatever was written to them.
- R10: With `reg_sel` and `reg_rd` both high, `reg_rdata` shows the two enable bits and the four pending bits at their positions in the same cycle. Otherwise it reads 0.
- R11: The four invalidate bits are independent. An acknowledge for one bit leaves the other pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data |
| inv_ack | input | 4 | Per-buffer invalidation acknowledge |
| inv_req | output | 4 | Per-buffer invalidation request levels |
| dbg_from_c0 | input | 1 | Debug request raised by core 0 |
| dbg_from_c1 | input | 1 | Debug request raised by core 1 |
| dbg_to_c0 | output | 1 | Gated debug request delivered to core 0 |
| dbg_to_c1 | output | 1 | Gated debug request delivered to core 1 |

## Verification
The bench first writes invalidate masks that set two non-adjacent bits. It then acknowledges them one at a time, which separates a per-bit clear from a clear of the whole group. A write of zeros over pending bits, a write coinciding with the acknowledge, and a stray acknowledge on clear bits then separate the three ways a bit can change. The debug gates are driven with both requests high under each of the four enable combinations, which exposes any swapped or crossed directions. An all-ones write to the reserved field shows whether any of it is stored.

// File: rtl/buf_inval_pkg.sv
package buf_inval_pkg;
   localparam int unsigned DEF_REG_W   = 24;
   localparam int unsigned DEF_NUM_BUF = 4;
   localparam int unsigned DEF_EN_LSB  = 22;

   typedef struct packed {
      logic c1_to_c0;
      logic c0_to_c1;
   } dbg_en_t;
endpackage

// File: rtl/inv_cell.sv
module inv_cell (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic ack_i,
   output logic pend_o
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (rst)
         pend_q <= 1'b0;
      else if (ack_i)
         pend_q <= 1'b0;
      else if (set_i)
         pend_q <= 1'b1;
   end

   assign pend_o = pend_q;

   // R3
   ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      ack_i |=> !pend_o);
   // R2
   set_take_chk: assert property (@(posedge clk) disable iff (rst)
      (set_i && !ack_i) |=> pend_o);
   // R4
   pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_o && !ack_i) |=> pend_o);
   // R6
   idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
      (!pend_o && !set_i) |=> !pend_o);
endmodule

// File: rtl/dbg_gate.sv
module dbg_gate
   import buf_inval_pkg::*;
(
   input  dbg_en_t en_i,
   input  logic    from_c0_i,
   input  logic    from_c1_i,
   output logic    to_c0_o,
   output logic    to_c1_o
);
   assign to_c0_o = from_c1_i & en_i.c1_to_c0;
   assign to_c1_o = from_c0_i & en_i.c0_to_c1;

   always_comb begin
      // R7
      gate_c1c0_chk: assert (en_i.c1_to_c0 || !to_c0_o);
      // R8
      gate_c0c1_chk: assert (en_i.c0_to_c1 || !to_c1_o);
   end
endmodule

// File: rtl/buf_inval_ctl.sv
module buf_inval_ctl
   import buf_inval_pkg::*;
#(
   parameter int unsigned REG_W   = DEF_REG_W,
   parameter int unsigned NUM_BUF = DEF_NUM_BUF,
   parameter int unsigned EN_LSB  = DEF_EN_LSB
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               reg_sel,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [NUM_BUF-1:0] inv_ack,
   output logic [NUM_BUF-1:0] inv_req,
   input  logic               dbg_from_c0,
   input  logic               dbg_from_c1,
   output logic               dbg_to_c0,
   output logic               dbg_to_c1
);
   localparam int unsigned EN_MSB = EN_LSB + 1;
   localparam int unsigned RSV_LO = NUM_BUF;
   localparam int unsigned RSV_HI = EN_LSB - 1;

   generate
      if (REG_W < EN_MSB + 1) begin : g_bad_width
         $error("REG_W too small for enable bits");
      end
      if (NUM_BUF + 1 > EN_LSB) begin : g_bad_bufs
         $error("invalidate field overlaps enable bits");
      end
   endgenerate

   logic           wr_hit;
   logic           rd_hit;
   dbg_en_t        en_q;
   logic [NUM_BUF-1:0] pend;
   logic [REG_W-1:0]   view;

   assign wr_hit = reg_sel & reg_wr;
   assign rd_hit = reg_sel & reg_rd;

   // one self-clearing cell per buffer
   generate
      for (genvar i = 0; i < NUM_BUF; i++) begin : g_cell
         inv_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (wr_hit & reg_wdata[i]),
            .ack_i  (inv_ack[i]),
            .pend_o (pend[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         en_q <= '0;
      else if (wr_hit) begin
         en_q.c1_to_c0 <= reg_wdata[EN_MSB];
         en_q.c0_to_c1 <= reg_wdata[EN_LSB];
      end
   end

   // reserved write data is deliberately dropped
   logic unused_rsv;
   assign unused_rsv = ^reg_wdata[RSV_HI:RSV_LO];

   generate
      if (REG_W > EN_MSB + 1) begin : g_top_pad
         logic unused_top;
         assign unused_top = ^reg_wdata[REG_W-1:EN_MSB+1];
      end
   endgenerate

   always_comb begin
      view                = '0;
      view[NUM_BUF-1:0]   = pend;
      view[EN_LSB]        = en_q.c0_to_c1;
      view[EN_MSB]        = en_q.c1_to_c0;
   end

   assign reg_rdata = rd_hit ? view : '0;
   assign inv_req   = pend;

   dbg_gate u_gate (
      .en_i      (en_q),
      .from_c0_i (dbg_from_c0),
      .from_c1_i (dbg_from_c1),
      .to_c0_o   (dbg_to_c0),
      .to_c1_o   (dbg_to_c1)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (inv_req == '0 && en_q == '0));
   // R9
   rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
      reg_rdata[RSV_HI:RSV_LO] == '0);
   // R10
   idle_read_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_hit |-> (reg_rdata == '0));
   // R11
   ack_local_chk: assert property (@(posedge clk) disable iff (rst)
      (inv_ack == '0 && !wr_hit) |=> $stable(inv_req));
endmodule

// File: tb/buf_inval_ctl_test.sv
`timescale 1ns/1ps
module buf_inval_ctl_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        reg_sel, reg_wr, reg_rd;
   logic [23:0] reg_wdata;
   logic [23:0] reg_rdata;
   logic [3:0]  inv_ack, inv_req;
   logic        dbg_from_c0, dbg_from_c1, dbg_to_c0, dbg_to_c1;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   buf_inval_ctl uut (
      .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .inv_ack(inv_ack), .inv_req(inv_req),
      .dbg_from_c0(dbg_from_c0), .dbg_from_c1(dbg_from_c1),
      .dbg_to_c0(dbg_to_c0), .dbg_to_c1(dbg_to_c1)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // write, optionally with an acknowledge in the same cycle
   task automatic do_write(input logic [23:0] d, input logic [3:0] ack);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d; inv_ack = ack;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0; inv_ack = '0;
   endtask

   task automatic do_ack(input logic [3:0] ack);
      @(negedge clk);
      inv_ack = ack;
      @(negedge clk);
      inv_ack = '0;
   endtask

   task automatic do_read(output logic [23:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_rd = 1'b1;
      #1 d = reg_rdata;
      reg_sel = 1'b0; reg_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [23:0] d;
      chk("R1 req after reset", inv_req, 0);
      do_read(d);
      chk("R1 read after reset", d, 0);
   endtask

   task automatic t_set_hold();
      logic [23:0] d;
      do_write(24'h000005, 4'h0);
      chk("R2 req after write", inv_req, 4'h5);
      repeat (3) @(negedge clk);
      chk("R2 req held as level", inv_req, 4'h5);
      do_read(d);
      chk("R10 pending readback", d, 24'h000005);
   endtask

   task automatic t_no_cancel();
      do_write(24'h000000, 4'h0);
      chk("R4 write 0 keeps pending", inv_req, 4'h5);
   endtask

   task automatic t_ack_each();
      do_ack(4'h1);
      chk("R3 ack bit0 clears", inv_req[0], 0);
      chk("R11 bit2 untouched", inv_req, 4'h4);
      do_ack(4'h4);
      chk("R3 ack bit2 clears", inv_req, 4'h0);
   endtask

   task automatic t_same_cycle();
      do_write(24'h000008, 4'h8);
      chk("R5 ack wins over set", inv_req, 4'h0);
   endtask

   task automatic t_stray_ack();
      do_ack(4'hF);
      chk("R6 stray ack no effect", inv_req, 4'h0);
      do_write(24'h000002, 4'h0);
      chk("R6 bit sets after stray ack", inv_req, 4'h2);
   endtask

   task automatic t_reserved();
      logic [23:0] d;
      do_write(24'hFFFFF0, 4'h0);
      do_read(d);
      chk("R9 reserved read zero", d, 24'hC00002);
   endtask

   task automatic t_debug();
      @(negedge clk);
      dbg_from_c0 = 1'b1; dbg_from_c1 = 1'b1;
      #1;
      chk("R7 both enabled c1->c0", dbg_to_c0, 1);
      chk("R8 both enabled c0->c1", dbg_to_c1, 1);
      do_write(24'h400000, 4'h0);
      chk("R7 c1->c0 blocked", dbg_to_c0, 0);
      chk("R8 c0->c1 passes", dbg_to_c1, 1);
      do_write(24'h800000, 4'h0);
      chk("R7 c1->c0 passes", dbg_to_c0, 1);
      chk("R8 c0->c1 blocked", dbg_to_c1, 0);
      dbg_from_c1 = 1'b0;
      #1;
      chk("R7 follows source low", dbg_to_c0, 0);
      do_write(24'h000000, 4'h0);
      dbg_from_c1 = 1'b1;
      #1;
      chk("R7 both blocked c0", dbg_to_c0, 0);
      chk("R8 both blocked c1", dbg_to_c1, 0);
      dbg_from_c0 = 1'b0; dbg_from_c1 = 1'b0;
   endtask

   task automatic t_read_gate();
      @(negedge clk);
      reg_sel = 1'b0; reg_rd = 1'b1;
      #1 chk("R10 no select reads 0", reg_rdata, 0);
      reg_rd = 1'b0;
      do_ack(4'h2);
      chk("R3 ack bit1 clears", inv_req, 4'h0);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      rst = 1'b1; reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
      inv_ack = '0; dbg_from_c0 = 0; dbg_from_c1 = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_set_hold();
      t_no_cancel();
      t_ack_each();
      t_same_cycle();
      t_stray_ack();
      t_reserved();
      t_debug();
      t_read_gate();
      repeat (2) @(negedge clk);
      finish_up();
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end
endmodule